// File: doc/BRIEF.md
# Edge-Triggered Burst DMA Sequencer

This block sequences one DMA channel that moves data in burst mode with single-address transfers, started by an edge on an active-low request line. It registers the request line and treats a high-to-low change as a start request. It accepts that request only while the channel is idle and has transfers left to do. It answers with a single request-acknowledge pulse and waits a programmable number of clocks, at least three, so that bus-grant latency can be modelled. It then runs one dummy bus cycle, which moves no counted data and carries no device acknowledge. After that it runs data cycles back to back until the remaining count reaches zero. The request line is not looked at again until the burst is over.

Either of two halt inputs, a non-maskable interrupt or an address error, stops the burst. A data cycle already under way still completes and is counted. The remaining count is kept and a halt flag is raised. To resume, the channel needs a new falling edge, which clears the flag, pulses the acknowledge once and inserts another dummy cycle before the rest of the transfers. Software loads the count through a simple load port while the channel is idle; a loaded zero stands for the full 65536 transfers.

Top module: `burst_dma_seq`

## Requirements
- R1: A falling edge on `xfer_req_n` (high in one sampled cycle, low in the next) starts a burst only when the channel is idle and `rem_cnt` is nonzero; otherwise it has no effect, so `req_ack` and `bus_cyc` stay low.
- R2: `req_ack` is high for exactly one clock, in the cycle after the accepting edge, and only once per burst; request edges seen while a burst is active are ignored.
- R3: The single dummy cycle (`dummy_cyc`=1, `bus_cyc`=1, `dev_ack`=0) comes exactly WAIT_CYC clocks after the `req_ack` cycle (3 with the defaults), and `rem_cnt` does not change across it.
- R4: Data cycles follow the dummy cycle directly with no gap. Each one lasts one clock with `dev_ack`=1 and `bus_cyc`=1, and `rem_cnt` drops by one at its end.
- R5: When `rem_cnt` reaches zero the burst ends, and `xfer_end` goes high and stays high until the next count load.
- R6: A load pulse while idle sets `rem_cnt` to `cnt_wdata` and clears `xfer_end`; a written 0 sets `rem_cnt` to 65536. A load pulse during an active burst is ignored.
- R7: A halt (`halt_nmi` or `halt_addr_err`) during a data cycle lets that cycle complete and be counted. The channel then goes idle with `halt_flag`=1 and the remaining count kept. A halt during the wait or dummy cycle stops the channel without counting. If the halted cycle is the last transfer, the completion takes precedence: `xfer_end`=1 and `halt_flag`=0.
- R8: After a halt, a new falling edge clears `halt_flag` by the `req_ack` cycle. The channel then gives one `req_ack` and one dummy cycle, and runs exactly the remaining transfers.
- R9: After reset, all strobes, `xfer_end`, `halt_flag` and `rem_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_load | input | 1 | Count load strobe (honoured only when idle) |
| cnt_wdata | input | CNT_W | Count to load; 0 means 2^CNT_W |
| xfer_req_n | input | 1 | Active-low transfer request, falling-edge detected |
| halt_nmi | input | 1 | Non-maskable interrupt halt request |
| halt_addr_err | input | 1 | Address error halt request |
| req_ack | output | 1 | One-clock acknowledge of an accepted request |
| dev_ack | output | 1 | Device acknowledge, high during each data cycle |
| bus_cyc | output | 1 | High during the dummy cycle and the data cycles |
| dummy_cyc | output | 1 | High during the dummy cycle |
| xfer_end | output | 1 | Count reached zero; held until the next load |
| halt_flag | output | 1 | Burst halted with transfers left |
| rem_cnt | output | CNT_W+1 | Remaining transfer count |

## Verification
The bench measures the distance from the acknowledge to the dummy cycle and from the dummy cycle to the first data cycle. A sequencer with the wait counter off by one, or one that counts the dummy cycle, would shift one of those distances or finish one transfer short. It drives halts on a middle transfer, on the last transfer and during the wait, then resumes. A design that drops the in-flight transfer, leaves the flag set after resuming, or skips the second dummy cycle would report the wrong remaining count or the wrong flags. It also drives request edges and count loads in the middle of a burst, and a zero load that must run 65536 transfers. A design that samples the request more than once, or lets software overwrite a running count, would add an acknowledge or change the transfer total.

// File: rtl/burst_dma_pkg.sv
package burst_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DUMMY = 2'd2,
    ST_DATA  = 2'd3
  } dma_state_e;
endpackage

// File: rtl/burst_dma_edge.sv
module burst_dma_edge (
  input  logic clk,
  input  logic rst,
  input  logic req_n,
  output logic req_fall
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b1;
    else     req_q <= req_n;
  end

  // previous sample high, present sample low
  assign req_fall = req_q & ~req_n;
endmodule

// File: rtl/burst_dma_count.sv
module burst_dma_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] wdata,
  input  logic             dec,
  output logic [CNT_W:0]   rem,
  output logic             rem_zero,
  output logic             rem_one,
  output logic             xfer_end
);
  localparam int REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem      <= '0;
      xfer_end <= 1'b0;
    end else if (load) begin
      rem      <= (wdata == '0) ? FULL : {1'b0, wdata};
      xfer_end <= 1'b0;
    end else if (dec) begin
      rem <= rem - REM_W'(1);
      if (rem == REM_W'(1)) xfer_end <= 1'b1;
    end
  end

  assign rem_zero = (rem == '0);
  assign rem_one  = (rem == REM_W'(1));
endmodule

// File: rtl/burst_dma_fsm.sv
module burst_dma_fsm
  import burst_dma_pkg::*;
#(
  parameter int WAIT_CYC = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_fall,
  input  logic       halt_req,
  input  logic       rem_zero,
  input  logic       rem_one,
  output dma_state_e state_q,
  output dma_state_e state_nxt,
  output logic       accept,
  output logic       dec,
  output logic       halt_flag
);
  localparam int WAIT_EFF = (WAIT_CYC < 3) ? 3 : WAIT_CYC;
  localparam int WCNT_W   = $clog2(WAIT_EFF);

  logic [WCNT_W-1:0] wcnt;
  logic              halt_stop;

  always_comb begin
    state_nxt = state_q;
    accept    = 1'b0;
    halt_stop = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_fall && !rem_zero) begin
          state_nxt = ST_WAIT;
          accept    = 1'b1;
        end
      end
      ST_WAIT: begin
        if (halt_req) begin
          state_nxt = ST_IDLE;
          halt_stop = 1'b1;
        end else if (wcnt == '0) begin
          state_nxt = ST_DUMMY;
        end
      end
      ST_DUMMY: begin
        if (halt_req) begin
          state_nxt = ST_IDLE;
          halt_stop = 1'b1;
        end else begin
          state_nxt = ST_DATA;
        end
      end
      ST_DATA: begin
        if (rem_one) begin
          state_nxt = ST_IDLE;
        end else if (halt_req) begin
          state_nxt = ST_IDLE;
          halt_stop = 1'b1;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      wcnt      <= '0;
      halt_flag <= 1'b0;
    end else begin
      state_q <= state_nxt;
      if (accept)
        wcnt <= WCNT_W'(WAIT_EFF - 1);
      else if (state_q == ST_WAIT && wcnt != '0)
        wcnt <= wcnt - WCNT_W'(1);
      if (accept)         halt_flag <= 1'b0;
      else if (halt_stop) halt_flag <= 1'b1;
    end
  end

  assign dec = (state_q == ST_DATA);
endmodule

// File: rtl/burst_dma_out.sv
module burst_dma_out
  import burst_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  dma_state_e state_nxt,
  output logic       req_ack,
  output logic       dev_ack,
  output logic       bus_cyc,
  output logic       dummy_cyc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_ack   <= 1'b0;
      dev_ack   <= 1'b0;
      bus_cyc   <= 1'b0;
      dummy_cyc <= 1'b0;
    end else begin
      req_ack   <= accept;
      dev_ack   <= (state_nxt == ST_DATA);
      bus_cyc   <= (state_nxt == ST_DATA) || (state_nxt == ST_DUMMY);
      dummy_cyc <= (state_nxt == ST_DUMMY);
    end
  end
endmodule

// File: rtl/burst_dma_seq.sv
module burst_dma_seq
  import burst_dma_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int WAIT_CYC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             xfer_req_n,
  input  logic             halt_nmi,
  input  logic             halt_addr_err,
  output logic             req_ack,
  output logic             dev_ack,
  output logic             bus_cyc,
  output logic             dummy_cyc,
  output logic             xfer_end,
  output logic             halt_flag,
  output logic [CNT_W:0]   rem_cnt
);
  dma_state_e state_q, state_nxt;
  logic req_fall, accept, dec, rem_zero, rem_one, load_ok;

  burst_dma_edge edge_i (
    .clk(clk), .rst(rst), .req_n(xfer_req_n), .req_fall(req_fall)
  );

  // count writes are honoured only while the channel is idle (R6)
  assign load_ok = cnt_load && (state_q == ST_IDLE);

  burst_dma_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst(rst), .load(load_ok), .wdata(cnt_wdata), .dec(dec),
    .rem(rem_cnt), .rem_zero(rem_zero), .rem_one(rem_one),
    .xfer_end(xfer_end)
  );

  burst_dma_fsm #(.WAIT_CYC(WAIT_CYC)) fsm_i (
    .clk(clk), .rst(rst), .req_fall(req_fall),
    .halt_req(halt_nmi | halt_addr_err),
    .rem_zero(rem_zero), .rem_one(rem_one),
    .state_q(state_q), .state_nxt(state_nxt), .accept(accept),
    .dec(dec), .halt_flag(halt_flag)
  );

  burst_dma_out out_i (
    .clk(clk), .rst(rst), .accept(accept), .state_nxt(state_nxt),
    .req_ack(req_ack), .dev_ack(dev_ack), .bus_cyc(bus_cyc),
    .dummy_cyc(dummy_cyc)
  );
endmodule

// File: rtl/burst_dma_seq_chk.sv
module burst_dma_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           cnt_load,
  input logic           req_ack,
  input logic           dev_ack,
  input logic           bus_cyc,
  input logic           dummy_cyc,
  input logic           xfer_end,
  input logic           halt_flag,
  input logic [CNT_W:0] rem_cnt
);
  assert_ack_single_R2: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  assert_ack_no_bus_R2: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> !bus_cyc);

  assert_start_needs_count_R1: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> rem_cnt != '0);

  assert_dummy_no_dack_R3: assert property (@(posedge clk) disable iff (rst)
    dummy_cyc |-> (bus_cyc && !dev_ack));

  assert_dummy_uncounted_R3: assert property (@(posedge clk) disable iff (rst)
    dummy_cyc |=> $stable(rem_cnt));

  assert_data_decrements_R4: assert property (@(posedge clk) disable iff (rst)
    dev_ack |=> rem_cnt == $past(rem_cnt) - 1'b1);

  assert_end_held_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer_end && !cnt_load) |=> xfer_end);

  assert_halt_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_flag) |-> !bus_cyc);
endmodule

bind burst_dma_seq burst_dma_seq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .cnt_load(cnt_load), .req_ack(req_ack),
  .dev_ack(dev_ack), .bus_cyc(bus_cyc), .dummy_cyc(dummy_cyc),
  .xfer_end(xfer_end), .halt_flag(halt_flag), .rem_cnt(rem_cnt)
);

// File: tb/burst_dma_seq_tb_top.sv
module burst_dma_seq_tb_top;
  localparam int CNT_W = 16;
  localparam int WAIT_CYC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_load = 1'b0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic xfer_req_n = 1'b1;
  logic halt_nmi = 1'b0;
  logic halt_addr_err = 1'b0;
  logic req_ack, dev_ack, bus_cyc, dummy_cyc, xfer_end, halt_flag;
  logic [CNT_W:0] rem_cnt;

  always #10 clk = ~clk;

  burst_dma_seq #(.CNT_W(CNT_W), .WAIT_CYC(WAIT_CYC)) dut_i (
    .clk(clk), .rst(rst), .cnt_load(cnt_load), .cnt_wdata(cnt_wdata),
    .xfer_req_n(xfer_req_n), .halt_nmi(halt_nmi), .halt_addr_err(halt_addr_err),
    .req_ack(req_ack), .dev_ack(dev_ack), .bus_cyc(bus_cyc),
    .dummy_cyc(dummy_cyc), .xfer_end(xfer_end), .halt_flag(halt_flag),
    .rem_cnt(rem_cnt)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        ld;
    logic [15:0] val;
    logic [7:0]  halt_at;
    logic        aerr;
    logic        noise;
    logic [16:0] xf;
    logic        end_f;
    logic        hlt;
    logic [16:0] rem;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b1, 16'd5, 8'd0, 1'b0, 1'b0, 17'd5, 1'b1, 1'b0, 17'd0},
    '{1'b1, 16'd1, 8'd0, 1'b0, 1'b0, 17'd1, 1'b1, 1'b0, 17'd0},
    '{1'b1, 16'd8, 8'd3, 1'b0, 1'b0, 17'd3, 1'b0, 1'b1, 17'd5},
    '{1'b0, 16'd0, 8'd2, 1'b1, 1'b0, 17'd2, 1'b0, 1'b1, 17'd3},
    '{1'b0, 16'd0, 8'd0, 1'b0, 1'b0, 17'd3, 1'b1, 1'b0, 17'd0},
    '{1'b1, 16'd2, 8'd2, 1'b0, 1'b0, 17'd2, 1'b1, 1'b0, 17'd0},
    '{1'b1, 16'd6, 8'd0, 1'b0, 1'b1, 17'd6, 1'b1, 1'b0, 17'd0}
  };

  // results of the last burst
  int r_acks, r_dums, r_xf, r_ack_i, r_dum_i, r_dat_i;
  bit r_overlap, r_hflag_at_ack;

  task automatic load_cnt(input logic [CNT_W-1:0] v);
    @(negedge clk);
    cnt_load  = 1'b1;
    cnt_wdata = v;
    @(negedge clk);
    cnt_load  = 1'b0;
  endtask

  task automatic run_burst(input int halt_at, input bit aerr, input bit noise);
    int cyc;
    bit seen;
    bit done;
    cyc = 0; seen = 0; done = 0;
    r_acks = 0; r_dums = 0; r_xf = 0; r_ack_i = -1; r_dum_i = -1; r_dat_i = -1;
    r_overlap = 0; r_hflag_at_ack = 0;
    @(negedge clk);
    xfer_req_n = 1'b0;
    while (!done && cyc < 70000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) xfer_req_n = 1'b1;
      if (req_ack) begin
        r_acks++; r_ack_i = cyc; r_hflag_at_ack = halt_flag;
      end
      if (dummy_cyc) begin
        r_dums++; r_dum_i = cyc;
        if (dev_ack) r_overlap = 1;
      end
      if (dev_ack) begin
        r_xf++;
        if (r_dat_i < 0) r_dat_i = cyc;
      end
      halt_nmi = 1'b0; halt_addr_err = 1'b0; cnt_load = 1'b0;
      if (halt_at != 0 && dev_ack && r_xf == halt_at) begin
        if (aerr) halt_addr_err = 1'b1;
        else      halt_nmi = 1'b1;
      end
      if (noise && dev_ack && r_xf == 2) begin
        xfer_req_n = 1'b0;
        cnt_load   = 1'b1;
        cnt_wdata  = 16'd100;
      end
      if (noise && dev_ack && r_xf == 3) xfer_req_n = 1'b1;
      if (bus_cyc) seen = 1;
      if (seen && !bus_cyc) done = 1;
    end
    halt_nmi = 1'b0; halt_addr_err = 1'b0; cnt_load = 1'b0; xfer_req_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk("R9 req_ack", req_ack, 0);
    chk("R9 bus_cyc", bus_cyc, 0);
    chk("R9 dev_ack", dev_ack, 0);
    chk("R9 xfer_end", xfer_end, 0);
    chk("R9 halt_flag", halt_flag, 0);
    chk("R9 rem_cnt", rem_cnt, 0);

    // R1: edge with zero count is ignored
    begin
      int acks_z = 0;
      xfer_req_n = 1'b0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        xfer_req_n = 1'b1;
        if (req_ack || bus_cyc) acks_z++;
      end
      chk("R1 edge with zero count", acks_z, 0);
    end

    // table of bursts
    for (int v = 0; v < 7; v++) begin
      if (VECS[v].ld) begin
        load_cnt(VECS[v].val);
        chk("R6 load sets count", rem_cnt, VECS[v].val);
        chk("R6 load clears end", xfer_end, 0);
      end
      run_burst(int'(VECS[v].halt_at), VECS[v].aerr, VECS[v].noise);
      chk("R2 one ack per burst", r_acks, 1);
      chk("R8 halt flag clear at ack", r_hflag_at_ack, 0);
      chk("R3 one dummy cycle", r_dums, 1);
      chk("R3 dummy offset from ack", r_dum_i - r_ack_i, WAIT_CYC);
      chk("R3 no dev_ack in dummy", r_overlap, 0);
      chk("R4 data follows dummy", r_dat_i - r_dum_i, 1);
      chk("R4 R7 transfer total", r_xf, VECS[v].xf);
      @(negedge clk);
      chk("R7 remaining count", rem_cnt, VECS[v].rem);
      chk("R5 end flag", xfer_end, VECS[v].end_f);
      chk("R7 halt flag", halt_flag, VECS[v].hlt);
    end

    // R5: end flag holds while idle
    repeat (5) @(negedge clk);
    chk("R5 end flag held", xfer_end, 1);

    // R7: halt during the wait, then R8 resume
    load_cnt(16'd4);
    begin
      int busy = 0;
      xfer_req_n = 1'b0;
      @(negedge clk);
      xfer_req_n = 1'b1;
      chk("R2 ack before wait halt", req_ack, 1);
      halt_nmi = 1'b1;
      @(negedge clk);
      halt_nmi = 1'b0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (bus_cyc) busy++;
      end
      chk("R7 no bus cycle after wait halt", busy, 0);
      chk("R7 halt flag after wait halt", halt_flag, 1);
      chk("R7 count kept after wait halt", rem_cnt, 4);
    end
    run_burst(0, 1'b0, 1'b0);
    chk("R8 resume ack", r_acks, 1);
    chk("R8 resume dummy", r_dums, 1);
    chk("R8 resume transfers", r_xf, 4);
    @(negedge clk);
    chk("R8 halt flag cleared", halt_flag, 0);

    // R6: zero load means full range
    load_cnt(16'd0);
    chk("R6 zero load", rem_cnt, 65536);
    run_burst(0, 1'b0, 1'b0);
    chk("R6 full range transfers", r_xf, 65536);
    @(negedge clk);
    chk("R5 end after full range", xfer_end, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule